// File: doc/BRIEF.md
# Multiprocessor-Aware Asynchronous Serial Receiver

This block recovers asynchronous serial frames from a single line input. It works from a
one-cycle enable pulse that arrives sixteen times per bit period. A two-flop synchronizer
conditions the line. While idle, the line is watched on every enable pulse. A high-to-low
change starts a frame and restarts the bit-phase counter at once, so each bit is sampled
three times near its centre and resolved by a two-of-three vote.

The frame format comes from a two-bit format code. Code 01 is start, 8 data bits (least
significant first), stop. Codes 10 and 11 insert a ninth data bit before the stop bit.
Code 00 belongs to a synchronous mode outside this block, so the receiver stays idle.

A finished frame is stored only if two conditions hold. First, software has acknowledged
the previous frame, so the receive flag is clear. Second, address filtering is off, or the
filter bit is 1. The filter bit is the stop bit in 8-bit frames and the ninth bit in 9-bit
frames. A frame that fails either condition is lost. A stop bit that samples 0 raises a
sticky framing-error flag, even when the frame is lost. That flag is shown on a shared
status output when a select input asks for it; otherwise the output shows the upper format
bit.

Controller states:
- `S_IDLE`: waiting for an edge.
- `S_START`: checking the start bit.
- `S_DATA`: eight data bits.
- `S_NINTH`: the extra bit, in the 9-bit formats.
- `S_STOP`: the stop bit, where the load decision is made.

Transitions:
- idle→start: on an edge.
- start→idle: when the start bit votes 1.
- start→data: when the start bit votes 0.
- data→ninth: after bit 7, in the 9-bit formats.
- data→stop: after bit 7, in the 8-bit format.
- ninth→stop: after the extra bit.
- stop→idle: always, after the stop sample.

Top module: `mpuart_rx`

## Requirements
- R1: While in `S_IDLE` with a nonzero format code, a 1 followed by a 0 on consecutive enable pulses of the synchronized line starts a frame. The bit-phase counter is 0 on the pulse that sees the 0.
- R2: Each bit value is the majority of the synchronized line at counter states 7, 8 and 9, so a glitch that corrupts one of the three samples does not change the received bit.
- R3: A start bit whose vote is 1 abandons the frame and returns to `S_IDLE`, and a later valid frame is then received normally.
- R4: In format 01, data bits arrive least significant bit first. A stored frame puts the 8 data bits in `rx_data` and the stop bit in `rx_bit9`.
- R5: A frame that completes while `rx_flag` is 1 is discarded, and `rx_data`/`rx_bit9` keep their previous values.
- R6: With `mp_filter_en`=1, a frame whose filter bit is 0 is discarded and a frame whose filter bit is 1 is stored. The filter bit is the stop bit in format 01 and the ninth bit in formats 10/11. With `mp_filter_en`=0, the filter bit does not gate storage.
- R7: `rx_flag` rises on the stop-bit sample (counter state 9 of the stop bit) of a stored frame. It stays 1 until a `rx_flag_clr` pulse clears it.
- R8: Formats 10 and 11 receive start, 8 data, ninth bit and stop, with the ninth bit stored in `rx_bit9`. Format 00 never starts a frame.
- R9: A stop bit voted 0 sets a framing-error flag, even if the frame is discarded. The flag holds until `fe_clr`. `stat_bit` shows this flag when `fe_show_sel`=1 and `mode_sel[1]` when `fe_show_sel`=0.
- R10: The receiver returns to `S_IDLE` right after the stop-bit sample, so a frame starting at the end of the previous stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| mode_sel | input | 2 | Format code: 00 none, 01 8-bit, 10/11 9-bit |
| mp_filter_en | input | 1 | Enable address filtering on the filter bit |
| fe_show_sel | input | 1 | Show framing error on stat_bit |
| rx_flag_clr | input | 1 | Clear receive flag (pulse) |
| fe_clr | input | 1 | Clear framing-error flag (pulse) |
| rx_data | output | 8 | Last stored data byte |
| rx_bit9 | output | 1 | Stop bit (format 01) or ninth bit (formats 10/11) of last stored frame |
| rx_flag | output | 1 | Receive-complete flag |
| stat_bit | output | 1 | Framing error or `mode_sel[1]`, per fe_show_sel |

## Verification
The bench builds the block with its defaults: 16 samples per bit, a two-flop synchronizer, and an 8-bit data byte. It drives one enable pulse every four clocks, so a frame takes only a few hundred cycles. That four-clock spacing lets a glitch exactly one pulse wide hit a single vote sample. It also lets a false start end well before the centre samples. The short frames bring back-to-back frames, the overrun drop and all three format codes into one short run.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_NINTH = 3'd3,
        S_STOP  = 3'd4
    } rx_state_t;

    localparam logic [1:0] FMT_NONE  = 2'b00;
    localparam logic [1:0] FMT_8BIT  = 2'b01;
endpackage

// File: rtl/mpuart_rx_sync.sv
module mpuart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b1;
                end else if (g == 0) begin
                    chain[g] <= din;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpuart_rx_sampler.sv
module mpuart_rx_sampler #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic restart,
    input  logic active,
    output logic bit_strobe,
    output logic bit_val
);
    localparam int CW   = $clog2(OVS);
    localparam int SMPA = OVS/2 - 1;
    localparam int SMPB = OVS/2;
    localparam int SMPC = OVS/2 + 1;

    logic [CW-1:0] phase;
    logic          vote_a;
    logic          vote_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            vote_a <= 1'b1;
            vote_b <= 1'b1;
        end else if (tick) begin
            if (restart) begin
                phase <= '0;
            end else if (active) begin
                phase <= phase + 1'b1;
                if (phase == CW'(SMPA)) vote_a <= line;
                if (phase == CW'(SMPB)) vote_b <= line;
            end
        end
    end

    assign bit_strobe = tick && active && !restart && (phase == CW'(SMPC));
    assign bit_val    = (vote_a & vote_b) | (vote_a & line) | (vote_b & line);

    // R1: restart always realigns the phase counter to zero
    a_r1_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart) |=> (phase == '0));
endmodule

// File: rtl/mpuart_rx_ctrl.sv
module mpuart_rx_ctrl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic [1:0]    mode_sel,
    input  logic          mp_filter_en,
    input  logic          rx_flag_clr,
    input  logic          fe_clr,
    input  logic          bit_strobe,
    input  logic          bit_val,
    output logic          restart,
    output logic          active,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_flag,
    output logic          fe_flag
);
    import mpuart_rx_pkg::*;

    localparam int BW = $clog2(DW);

    rx_state_t     state, state_nx;
    logic          line_prev;
    logic [BW-1:0] bidx;
    logic [DW-1:0] shreg;
    logic          ninth;
    logic          nine_fmt;
    logic          filt_bit;
    logic          accept;

    assign nine_fmt = mode_sel[1];
    assign restart  = (state == S_IDLE) && tick && line_prev && !line
                      && (mode_sel != FMT_NONE);
    assign active   = (state != S_IDLE);
    assign filt_bit = nine_fmt ? ninth : bit_val;
    assign accept   = !rx_flag && (!mp_filter_en || filt_bit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (restart) state_nx = S_START;
            S_START: if (bit_strobe) state_nx = bit_val ? S_IDLE : S_DATA;
            S_DATA:  if (bit_strobe && (bidx == BW'(DW-1)))
                         state_nx = nine_fmt ? S_NINTH : S_STOP;
            S_NINTH: if (bit_strobe) state_nx = S_STOP;
            S_STOP:  if (bit_strobe) state_nx = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_prev <= 1'b1;
            bidx      <= '0;
            shreg     <= '0;
            ninth     <= 1'b0;
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_flag   <= 1'b0;
            fe_flag   <= 1'b0;
        end else begin
            if (rx_flag_clr) rx_flag <= 1'b0;
            if (fe_clr)      fe_flag <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (tick) line_prev <= line;
                    bidx <= '0;
                end
                S_START: ;
                S_DATA: if (bit_strobe) begin
                    shreg <= {bit_val, shreg[DW-1:1]};
                    bidx  <= bidx + 1'b1;
                end
                S_NINTH: if (bit_strobe) ninth <= bit_val;
                S_STOP: if (bit_strobe) begin
                    line_prev <= line;
                    if (!bit_val) fe_flag <= 1'b1;
                    if (accept) begin
                        rx_data <= shreg;
                        rx_bit9 <= filt_bit;
                        rx_flag <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R5: a pending flag freezes the stored frame
    a_r5_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |=> ($stable(rx_data) && $stable(rx_bit9)));
    // R7: flag rises only out of the stop state and stays until cleared
    a_r7_rise_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> ($past(state) == S_STOP));
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !rx_flag_clr) |=> rx_flag);
    // R9: framing error is sticky until cleared
    a_r9_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_flag && !fe_clr) |=> fe_flag);
    // R8: format 00 keeps the receiver idle
    a_r8_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE) && (mode_sel == 2'b00)) |=> (state == S_IDLE));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
    parameter int OVS       = 16,
    parameter int SYNC_STGS = 2,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    mode_sel,
    input  logic          mp_filter_en,
    input  logic          fe_show_sel,
    input  logic          rx_flag_clr,
    input  logic          fe_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_flag,
    output logic          stat_bit
);
    logic line_s;
    logic restart;
    logic active;
    logic bit_strobe;
    logic bit_val;
    logic fe_flag;

    mpuart_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    mpuart_rx_sampler #(.OVS(OVS)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .line      (line_s),
        .restart   (restart),
        .active    (active),
        .bit_strobe(bit_strobe),
        .bit_val   (bit_val)
    );

    mpuart_rx_ctrl #(.DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .line        (line_s),
        .mode_sel    (mode_sel),
        .mp_filter_en(mp_filter_en),
        .rx_flag_clr (rx_flag_clr),
        .fe_clr      (fe_clr),
        .bit_strobe  (bit_strobe),
        .bit_val     (bit_val),
        .restart     (restart),
        .active      (active),
        .rx_data     (rx_data),
        .rx_bit9     (rx_bit9),
        .rx_flag     (rx_flag),
        .fe_flag     (fe_flag)
    );

    assign stat_bit = fe_show_sel ? fe_flag : mode_sel[1];
endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
    localparam int TDIV = 4;
    localparam int BITC = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] mode_sel = 2'b01;
    logic       mp_filter_en = 1'b0;
    logic       fe_show_sel = 1'b1;
    logic       rx_flag_clr = 1'b0;
    logic       fe_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_flag;
    logic       stat_bit;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tcnt   <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
        tick16 <= (tcnt == TDIV-1);
    end

    mpuart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .mode_sel(mode_sel), .mp_filter_en(mp_filter_en),
        .fe_show_sel(fe_show_sel), .rx_flag_clr(rx_flag_clr), .fe_clr(fe_clr),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag), .stat_bit(stat_bit)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bit, optional one-tick glitch at the centre
    task automatic drive_bit(input logic v, input logic glitch);
        rxd = v;
        if (glitch) begin
            clks(7*TDIV + 2); rxd = ~v;
            clks(TDIV);       rxd = v;
            clks(BITC - 8*TDIV - 2);
        end else begin
            clks(BITC);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic nine, input logic has9,
                              input logic stopv, input int gbit, input logic midchk,
                              input string req);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i], gbit == i);
        if (has9) drive_bit(nine, 1'b0);
        rxd = stopv;
        if (midchk) begin
            clks(3*TDIV);
            chk({req, " flag low early in stop"}, rx_flag, 0);
            clks(BITC - 3*TDIV);
            chk({req, " flag high end of stop"}, rx_flag, 1);
        end else begin
            clks(BITC);
        end
        rxd = 1'b1;
    endtask

    task automatic idle(input int bits);
        rxd = 1'b1;
        clks(bits * BITC);
    endtask

    task automatic clr_flag();
        rx_flag_clr = 1'b1; clks(1); rx_flag_clr = 1'b0; clks(1);
    endtask

    task automatic t_reset();
        chk("R7 reset flag", rx_flag, 0);
        chk("R4 reset data", rx_data, 0);
        chk("R4 reset bit9", rx_bit9, 0);
        chk("R9 reset fe", stat_bit, 0);
    endtask

    task automatic t_basic8();
        mode_sel = 2'b01;
        send_frame(8'hA5, 1'b0, 1'b0, 1'b1, -1, 1'b1, "R7");
        idle(1);
        chk("R4 data", rx_data, 8'hA5);
        chk("R4 stop in bit9", rx_bit9, 1);
        chk("R1 flag set", rx_flag, 1);
        clks(200);
        chk("R7 flag held", rx_flag, 1);
        clr_flag();
        chk("R7 flag cleared", rx_flag, 0);
    endtask

    task automatic t_glitch();
        send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 2, 1'b0, "R2");
        idle(1);
        chk("R2 glitch rejected", rx_data, 8'h3C);
        clr_flag();
        send_frame(8'hF0, 1'b0, 1'b0, 1'b1, 5, 1'b0, "R2");
        idle(1);
        chk("R2 glitch rejected 2", rx_data, 8'hF0);
        clr_flag();
    endtask

    task automatic t_false_start();
        rxd = 1'b0; clks(3*TDIV); rxd = 1'b1;
        idle(12);
        chk("R3 no frame from false start", rx_flag, 0);
        send_frame(8'h5A, 1'b0, 1'b0, 1'b1, -1, 1'b0, "R3");
        idle(1);
        chk("R3 frame after false start", rx_data, 8'h5A);
        chk("R3 flag after false start", rx_flag, 1);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 1'b0, 1'b0, 1'b1, -1, 1'b0, "R5");
        idle(1);
        chk("R5 data kept", rx_data, 8'h5A);
        chk("R5 flag still set", rx_flag, 1);
        clr_flag();
    endtask

    task automatic t_nine();
        mode_sel = 2'b11; mp_filter_en = 1'b1;
        send_frame(8'h42, 1'b0, 1'b1, 1'b1, -1, 1'b0, "R6");
        idle(1);
        chk("R6 ninth=0 filtered", rx_flag, 0);
        send_frame(8'h81, 1'b1, 1'b1, 1'b1, -1, 1'b0, "R6");
        idle(1);
        chk("R6 ninth=1 data", rx_data, 8'h81);
        chk("R6 ninth=1 bit9", rx_bit9, 1);
        clr_flag();
        mode_sel = 2'b10; mp_filter_en = 1'b0;
        send_frame(8'h7E, 1'b0, 1'b1, 1'b1, -1, 1'b0, "R8");
        idle(1);
        chk("R8 mode10 data", rx_data, 8'h7E);
        chk("R8 mode10 ninth", rx_bit9, 0);
        chk("R8 mode10 flag", rx_flag, 1);
        clr_flag();
    endtask

    task automatic t_framing();
        mode_sel = 2'b01; mp_filter_en = 1'b1;
        send_frame(8'h99, 1'b0, 1'b0, 1'b0, -1, 1'b0, "R9");
        idle(1);
        chk("R6 bad stop filtered", rx_flag, 0);
        chk("R9 fe set when discarded", stat_bit, 1);
        fe_show_sel = 1'b0; clks(1);
        chk("R9 shows mode bit 0", stat_bit, 0);
        mode_sel = 2'b11; clks(1);
        chk("R9 shows mode bit 1", stat_bit, 1);
        mode_sel = 2'b01; fe_show_sel = 1'b1;
        fe_clr = 1'b1; clks(1); fe_clr = 1'b0; clks(1);
        chk("R9 fe cleared", stat_bit, 0);
        mp_filter_en = 1'b0;
        send_frame(8'h66, 1'b0, 1'b0, 1'b0, -1, 1'b0, "R6");
        idle(1);
        chk("R6 unfiltered bad stop stored", rx_data, 8'h66);
        chk("R6 unfiltered bit9", rx_bit9, 0);
        chk("R9 fe set again", stat_bit, 1);
        clr_flag();
        fe_clr = 1'b1; clks(1); fe_clr = 1'b0; clks(1);
    endtask

    task automatic t_none();
        mode_sel = 2'b00;
        send_frame(8'h24, 1'b0, 1'b0, 1'b1, -1, 1'b0, "R8");
        idle(1);
        chk("R8 mode00 no frame", rx_flag, 0);
        chk("R8 mode00 data kept", rx_data, 8'h66);
        mode_sel = 2'b01;
    endtask

    task automatic t_b2b();
        send_frame(8'hC3, 1'b0, 1'b0, 1'b1, -1, 1'b0, "R10");
        clr_flag();
        send_frame(8'h3A, 1'b0, 1'b0, 1'b1, -1, 1'b0, "R10");
        idle(1);
        chk("R10 back-to-back data", rx_data, 8'h3A);
        chk("R10 back-to-back flag", rx_flag, 1);
        clr_flag();
    endtask

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(5);
        t_reset();
        idle(1);
        t_basic8();
        t_glitch();
        t_false_start();
        t_overrun();
        t_nine();
        t_framing();
        t_none();
        t_b2b();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule